// File: doc/BRIEF.md
# Exhaustive Key Search Controller

This controller recovers the secret key of a 16-character block that was enciphered with a stream cipher. It drives an external decryption engine with one candidate key after another. It starts at zero and counts upward through the whole key space. Each decrypted block is judged in a single cycle. The search stops at the first candidate whose every byte is a capital letter, a decimal digit or a space.

A one-cycle `go` pulse latches the ciphertext and begins the search. For each candidate the controller gives a one-cycle start to the engine. It then holds the key and ciphertext steady until the engine reports done with its plaintext. On success the key and the plaintext are held on result outputs, and a one-cycle draw strobe tells a text renderer to show them. The `timer_run` output stays high while the search is in progress, so an external stopwatch can time it. If every key fails, the controller parks in a not-found state.

Top module: `keysearch_ctrl`

## Requirements
- R1: After reset, `eng_start`, `draw_pulse`, `timer_run` and `not_found` are low, and `found_key` and `found_text` are zero.
- R2: A `go` pulse while idle or finished makes the first candidate key 0. Each candidate is launched with exactly one single-cycle `eng_start`. `eng_key` holds steady until the next launch.
- R3: After a rejected candidate, the next launch uses the previous key plus one. No key is skipped or repeated.
- R4: A plaintext is accepted only if every byte is 0x41 to 0x5A, 0x30 to 0x39 or 0x20. Any other byte rejects the candidate, including the neighbours 0x40, 0x5B, 0x2F, 0x3A, 0x1F and 0x61.
- R5: On acceptance, `found_key` takes the accepted candidate and `found_text` takes its plaintext, in the same cycle as a one-cycle `draw_pulse`. Both are held until the next accepted search.
- R6: `timer_run` is high from the cycle after `go` until the search ends. It is low while idle, found or exhausted.
- R7: If the all-ones key is also rejected, `not_found` goes high, `timer_run` drops and no `draw_pulse` is given.
- R8: A `go` pulse during a search is ignored. A `go` pulse in the found or exhausted state restarts the search from key 0 and clears `not_found`.
- R9: The ciphertext is sampled at `go` and stays on `eng_cipher` for the whole search, whatever `cipher_in` does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| go | input | 1 | Search start pulse |
| cipher_in | input | TEXT_BYTES*8 | Ciphertext block |
| eng_key | output | KEY_W | Candidate key to the engine |
| eng_cipher | output | TEXT_BYTES*8 | Latched ciphertext to the engine |
| eng_start | output | 1 | Single-cycle engine launch |
| eng_done | input | 1 | Engine result valid |
| eng_text | input | TEXT_BYTES*8 | Engine plaintext |
| found_key | output | KEY_W | Accepted key |
| found_text | output | TEXT_BYTES*8 | Accepted plaintext |
| draw_pulse | output | 1 | One-cycle strobe on acceptance |
| timer_run | output | 1 | High while searching |
| not_found | output | 1 | Key space exhausted |

## Verification
The main function is exercised with several kinds of target key:
- Directed targets at key 0, 7 and 9 separate an off-by-one start from a correct upward walk.
- Random targets with random printable messages and random engine latency show that the key is held correctly across the wait.
- An injected plaintext made of only the boundary characters `A`, `Z`, `0`, `9` and space shows that an earlier acceptable key wins.
- Injected plaintexts that carry one neighbouring character each separate a correct alphabet test from one with a widened range.
- A narrow-key instance with an engine that never returns printable text tells exhaustion apart from a wrap back to zero.

// File: rtl/ks_pkg.sv
package ks_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LAUNCH,
      ST_AWAIT,
      ST_JUDGE,
      ST_FOUND,
      ST_EXHAUST
   } ks_state_e;

   // Printable alphabet: capitals, decimal digits, space
   function automatic logic char_legal(input logic [7:0] c);
      logic cap, dig, spc;
      cap = (c >= 8'h41) && (c <= 8'h5A);
      dig = (c >= 8'h30) && (c <= 8'h39);
      spc = (c == 8'h20);
      return cap | dig | spc;
   endfunction

endpackage

// File: rtl/ks_text_filter.sv
module ks_text_filter #(
   parameter int TEXT_BYTES = 16,
   localparam int TEXT_W = TEXT_BYTES * 8
) (
   input  logic [TEXT_W-1:0] text,
   output logic              all_ok
);
   logic [TEXT_BYTES-1:0] byte_ok;

   for (genvar i = 0; i < TEXT_BYTES; i++) begin : g_byte
      assign byte_ok[i] = ks_pkg::char_legal(text[i*8 +: 8]);
   end

   assign all_ok = &byte_ok;
endmodule

// File: rtl/ks_key_walker.sv
module ks_key_walker #(
   parameter int KEY_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             step,
   output logic [KEY_W-1:0] key,
   output logic             at_last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     key <= '0;
      else if (clear) key <= '0;
      else if (step)  key <= key + KEY_W'(1);
   end

   assign at_last = &key;
endmodule

// File: rtl/ks_seq_fsm.sv
module ks_seq_fsm
   import ks_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go,
   input  logic      eng_done,
   input  logic      text_ok,
   input  logic      key_last,
   output ks_state_e state,
   output logic      launch,
   output logic      key_clear,
   output logic      key_step,
   output logic      grab_text,
   output logic      found_set,
   output logic      busy
);
   ks_state_e nxt;
   logic      resting;

   assign resting   = (state == ST_IDLE) || (state == ST_FOUND) || (state == ST_EXHAUST);
   assign key_clear = resting && go;
   assign grab_text = (state == ST_AWAIT) && eng_done;
   assign found_set = (state == ST_JUDGE) && text_ok;
   assign key_step  = (state == ST_JUDGE) && !text_ok && !key_last;
   assign launch    = (state == ST_LAUNCH);
   assign busy      = !resting;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE, ST_FOUND, ST_EXHAUST: if (go) nxt = ST_LAUNCH;
         ST_LAUNCH: nxt = ST_AWAIT;
         ST_AWAIT:  if (eng_done) nxt = ST_JUDGE;
         ST_JUDGE: begin
            if (text_ok)       nxt = ST_FOUND;
            else if (key_last) nxt = ST_EXHAUST;
            else               nxt = ST_LAUNCH;
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/keysearch_ctrl.sv
module keysearch_ctrl
   import ks_pkg::*;
#(
   parameter int KEY_W = 24,
   parameter int TEXT_BYTES = 16,
   localparam int TEXT_W = TEXT_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [TEXT_W-1:0] cipher_in,
   output logic [KEY_W-1:0]  eng_key,
   output logic [TEXT_W-1:0] eng_cipher,
   output logic              eng_start,
   input  logic              eng_done,
   input  logic [TEXT_W-1:0] eng_text,
   output logic [KEY_W-1:0]  found_key,
   output logic [TEXT_W-1:0] found_text,
   output logic              draw_pulse,
   output logic              timer_run,
   output logic              not_found
);
   if (KEY_W < 2) begin : g_bad_key
      $error("keysearch_ctrl: KEY_W must be at least 2");
   end
   if (TEXT_BYTES < 1) begin : g_bad_text
      $error("keysearch_ctrl: TEXT_BYTES must be at least 1");
   end

   ks_state_e         state;
   logic              key_clear, key_step, grab_text, found_set, busy;
   logic              key_last, text_ok;
   logic [TEXT_W-1:0] text_q;

   ks_seq_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .eng_done  (eng_done),
      .text_ok   (text_ok),
      .key_last  (key_last),
      .state     (state),
      .launch    (eng_start),
      .key_clear (key_clear),
      .key_step  (key_step),
      .grab_text (grab_text),
      .found_set (found_set),
      .busy      (busy)
   );

   ks_key_walker #(.KEY_W(KEY_W)) u_walk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (key_clear),
      .step    (key_step),
      .key     (eng_key),
      .at_last (key_last)
   );

   ks_text_filter #(.TEXT_BYTES(TEXT_BYTES)) u_filt (
      .text   (text_q),
      .all_ok (text_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         text_q     <= '0;
         eng_cipher <= '0;
         found_key  <= '0;
         found_text <= '0;
         draw_pulse <= 1'b0;
      end else begin
         if (key_clear) eng_cipher <= cipher_in;
         if (grab_text) text_q <= eng_text;
         if (found_set) begin
            found_key  <= eng_key;
            found_text <= text_q;
         end
         draw_pulse <= found_set;
      end
   end

   assign timer_run = busy;
   assign not_found = (state == ST_EXHAUST);
endmodule

// File: rtl/ks_search_chk.sv
module ks_search_chk #(
   parameter int KEY_W = 24,
   parameter int TEXT_BYTES = 16,
   localparam int TEXT_W = TEXT_BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              eng_start,
   input logic [KEY_W-1:0]  eng_key,
   input logic [TEXT_W-1:0] eng_cipher,
   input logic [KEY_W-1:0]  found_key,
   input logic [TEXT_W-1:0] found_text,
   input logic              draw_pulse,
   input logic              timer_run,
   input logic              not_found
);
   function automatic logic printable(input logic [TEXT_W-1:0] t);
      for (int i = 0; i < TEXT_BYTES; i++) begin
         logic [7:0] c;
         c = t[i*8 +: 8];
         if (!(c == 8'h20 || (c inside {[8'h30:8'h39]}) || (c inside {[8'h41:8'h5A]})))
            return 1'b0;
      end
      return 1'b1;
   endfunction

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start); // R2
   AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(timer_run) && timer_run && !eng_start) |-> $stable(eng_key)); // R2
   AST_KEY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(eng_key) && $past(timer_run)) |-> (eng_key == KEY_W'($past(eng_key) + KEY_W'(1)))); // R3
   AST_DRAW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      draw_pulse |-> printable(found_text)); // R4
   AST_DRAW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      draw_pulse |=> !draw_pulse); // R5
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!draw_pulse && !timer_run && !$past(timer_run)) |-> $stable(found_key)); // R5
   AST_IDLE_ON_DRAW: assert property (@(posedge clk) disable iff (!rst_n)
      draw_pulse |-> !timer_run); // R6
   AST_EXHAUST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      not_found |-> (!timer_run && !draw_pulse)); // R7
   AST_CIPHER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(timer_run) && timer_run) |-> $stable(eng_cipher)); // R9
endmodule

bind keysearch_ctrl ks_search_chk #(.KEY_W(KEY_W), .TEXT_BYTES(TEXT_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .eng_start  (eng_start),
   .eng_key    (eng_key),
   .eng_cipher (eng_cipher),
   .found_key  (found_key),
   .found_text (found_text),
   .draw_pulse (draw_pulse),
   .timer_run  (timer_run),
   .not_found  (not_found)
);

// File: tb/sim_keysearch_ctrl.sv
`timescale 1ns/1ps
module sim_keysearch_ctrl;
   localparam int KW  = 24;
   localparam int KW1 = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;

   // instance 0: full key width
   logic           go0 = 1'b0, done0 = 1'b0, start0, draw0, run0, nf0;
   logic [127:0]   cin0 = '0, text0 = '0, ecip0, ftext0;
   logic [KW-1:0]  ekey0, fkey0;

   // instance 1: narrow key, engine never yields printable text
   logic           go1 = 1'b0, done1 = 1'b0, start1, draw1, run1, nf1;
   logic [127:0]   cin1 = '0, ecip1, ftext1;
   logic [KW1-1:0] ekey1, fkey1;

   keysearch_ctrl #(.KEY_W(KW), .TEXT_BYTES(16)) u0 (
      .clk(clk), .rst_n(rst_n), .go(go0), .cipher_in(cin0),
      .eng_key(ekey0), .eng_cipher(ecip0), .eng_start(start0),
      .eng_done(done0), .eng_text(text0), .found_key(fkey0),
      .found_text(ftext0), .draw_pulse(draw0), .timer_run(run0),
      .not_found(nf0));

   keysearch_ctrl #(.KEY_W(KW1), .TEXT_BYTES(16)) u1 (
      .clk(clk), .rst_n(rst_n), .go(go1), .cipher_in(cin1),
      .eng_key(ekey1), .eng_cipher(ecip1), .eng_start(start1),
      .eng_done(done1), .eng_text(128'h0), .found_key(fkey1),
      .found_text(ftext1), .draw_pulse(draw1), .timer_run(run1),
      .not_found(nf1));

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // ---------- bench model of the cipher engine ----------
   bit           trap_on = 0;
   logic [KW-1:0] trap_key = '0;
   logic [127:0] trap_text = '0;

   function automatic logic [127:0] stream(input logic [KW-1:0] k);
      logic [127:0] s;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] x;
         x = {8'd0, k} * 32'h9E3779B1 + 32'(i) * 32'h85EBCA77;
         x = x ^ (x >> 15);
         x = x * 32'h2C1B3C6D;
         s[i*8 +: 8] = x[31:24];
      end
      return s;
   endfunction

   function automatic logic [127:0] decrypt(input logic [127:0] c, input logic [KW-1:0] k);
      if (trap_on && k == trap_key) return trap_text;
      return c ^ stream(k);
   endfunction

   function automatic bit legal(input logic [127:0] t);
      for (int i = 0; i < 16; i++) begin
         logic [7:0] c;
         c = t[i*8 +: 8];
         if (!(c == 8'h20 || (c >= 8'h30 && c <= 8'h39) || (c >= 8'h41 && c <= 8'h5A))) return 0;
      end
      return 1;
   endfunction

   function automatic logic [KW-1:0] first_key(input logic [127:0] c, input logic [KW-1:0] lim);
      for (int k = 0; k <= int'(lim); k++)
         if (legal(decrypt(c, KW'(k)))) return KW'(k);
      return lim;
   endfunction

   function automatic logic [7:0] rnd_char();
      int r;
      r = int'($urandom % 37);
      if (r < 26) return 8'(8'h41 + r);
      if (r < 36) return 8'(8'h30 + r - 26);
      return 8'h20;
   endfunction

   function automatic logic [127:0] rnd_msg();
      logic [127:0] m;
      for (int i = 0; i < 16; i++) m[i*8 +: 8] = rnd_char();
      return m;
   endfunction

   // ---------- engine responders and launch monitors ----------
   int lat0 = 0, lat1 = 0;
   int tries0 = 0, tries1 = 0, draws0 = 0, draws1 = 0;
   logic [KW-1:0]  nxt0 = '0;
   logic [KW1-1:0] nxt1 = '0;

   always @(negedge clk) begin
      done0 = 1'b0;
      if (lat0 != 0) begin
         lat0--;
         if (lat0 == 0) begin
            done0 = 1'b1;
            text0 = decrypt(ecip0, ekey0);
         end
      end
      if (start0) begin
         chk(ekey0 == nxt0, "R3 launch key in sequence (u0)", 128'(ekey0), 128'(nxt0));
         nxt0 = ekey0 + KW'(1);
         tries0++;
         lat0 = 1 + int'($urandom % 4);
      end
      if (draw0) draws0++;

      done1 = 1'b0;
      if (lat1 != 0) begin
         lat1--;
         if (lat1 == 0) done1 = 1'b1;
      end
      if (start1) begin
         chk(ekey1 == nxt1, "R3 launch key in sequence (u1)", 128'(ekey1), 128'(nxt1));
         nxt1 = ekey1 + KW1'(1);
         tries1++;
         lat1 = 1 + int'($urandom % 3);
      end
      if (draw1) draws1++;
   end

   // ---------- search drivers ----------
   task automatic search0(input logic [127:0] c, input logic [KW-1:0] exp_key,
                          input bit poke_mid, input string tag);
      int guard;
      logic [127:0] exp_text;
      exp_text = decrypt(c, exp_key);
      @(negedge clk);
      nxt0 = '0; tries0 = 0; draws0 = 0;
      cin0 = c; go0 = 1'b1;
      @(negedge clk);
      go0 = 1'b0;
      chk(run0 == 1'b1, {"R6 run after go ", tag}, 128'(run0), 128'd1);
      if (poke_mid) begin
         repeat (5) @(negedge clk);
         cin0 = rnd_msg(); go0 = 1'b1;  // R8 ignored mid-search, R9 new cipher_in unused
         @(negedge clk);
         go0 = 1'b0;
      end
      guard = 0;
      while (!draw0 && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      chk(draw0 == 1'b1, {"R5 draw strobe ", tag}, 128'(draw0), 128'd1);
      chk(fkey0 == exp_key, {"R5 found key ", tag}, 128'(fkey0), 128'(exp_key));
      chk(ftext0 == exp_text, {"R5 found text ", tag}, ftext0, exp_text);
      chk(run0 == 1'b0, {"R6 run low at end ", tag}, 128'(run0), 128'd0);
      chk(tries0 == int'(exp_key) + 1, {"R4 candidates tried ", tag}, 128'(tries0), 128'(int'(exp_key) + 1));
      @(negedge clk);
      chk(draws0 == 1 && !draw0, {"R5 single draw ", tag}, 128'(draws0), 128'd1);
      repeat (3) @(negedge clk);
      chk(fkey0 == exp_key, {"R5 key held ", tag}, 128'(fkey0), 128'(exp_key));
   endtask

   task automatic plant(input logic [KW-1:0] k, output logic [127:0] c);
      c = rnd_msg() ^ stream(k);
   endtask

   // ---------- main sequence ----------
   initial begin
      logic [127:0] c, t;
      logic [KW-1:0] k;
      logic [7:0] bad [6];
      bad = '{8'h40, 8'h5B, 8'h2F, 8'h3A, 8'h1F, 8'h61};
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      chk(!start0 && !draw0 && !run0 && !nf0, "R1 reset controls", {draw0, run0, nf0, start0}, 128'd0);
      chk(fkey0 == '0 && ftext0 == '0, "R1 reset results", ftext0, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed targets: R2 start at zero
      plant(24'd0, c);  search0(c, first_key(c, 24'd0), 0, "R2 key 0");
      plant(24'd7, c);  search0(c, first_key(c, 24'd7), 0, "key 7");
      plant(24'd9, c);  search0(c, first_key(c, 24'd9), 0, "key 9");

      // R4 boundary characters all accepted at an earlier key
      t = rnd_msg();
      t[7:0] = 8'h41; t[15:8] = 8'h5A; t[23:16] = 8'h30; t[31:24] = 8'h39; t[39:32] = 8'h20;
      trap_on = 1; trap_key = 24'd5; trap_text = t;
      plant(24'd12, c);
      search0(c, 24'd5, 0, "R4 boundary accept");

      // R4 one neighbouring byte rejects the candidate
      foreach (bad[j]) begin
         t = rnd_msg();
         t[($urandom % 16) * 8 +: 8] = bad[j];
         trap_key = 24'd3; trap_text = t;
         plant(24'd6, c);
         search0(c, first_key(c, 24'd6), 0, "R4 neighbour reject");
      end
      trap_on = 0;

      // random targets
      for (int n = 0; n < 16; n++) begin
         k = KW'($urandom % 31);
         plant(k, c);
         search0(c, first_key(c, k), 0, "random");
      end

      // R8 / R9: go and new cipher_in mid-search
      plant(24'd20, c);
      search0(c, first_key(c, 24'd20), 1, "R8 R9 mid-search go");
      chk(ecip0 == c, "R9 latched cipher", ecip0, c);

      // R7 exhaustion on the narrow instance
      for (int pass = 0; pass < 2; pass++) begin
         int guard;
         @(negedge clk);
         nxt1 = '0; tries1 = 0; draws1 = 0;
         cin1 = rnd_msg(); go1 = 1'b1;
         @(negedge clk);
         go1 = 1'b0;
         chk(!nf1 && run1, "R8 restart clears not_found", {nf1, run1}, 128'd1);
         guard = 0;
         while (!nf1 && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         chk(nf1 == 1'b1, "R7 not_found", 128'(nf1), 128'd1);
         chk(run1 == 1'b0, "R7 run low", 128'(run1), 128'd0);
         chk(tries1 == 16, "R7 whole space tried", 128'(tries1), 128'd16);
         chk(draws1 == 0, "R7 no draw", 128'(draws1), 128'd0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule